// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block generates two independent pulse-width modulated outputs. Each channel steps a period counter at a rate set by a per-channel clock divider. The output sits at the channel's active level while the counter is below the programmed duty count, and at the opposite level for the rest of the period. Software programs the block through a single-cycle register port. Each write takes effect on the clock edge that samples the strobe. Reads are combinational from the address.

Three 32-bit words are visible on the port, at byte offsets 0x0, 0x4 and 0x8. The control word holds one 10-bit field group per channel, starting at bit 15 × channel. Channel 0's timing word is at 0x4 and channel 1's is at 0x8.

A timing word does not reach the running counter at once. It waits in a holding register, and the channel's busy flag stays high until the counter reaches the end of its current period. While busy is high, further timing writes to that channel are refused. A stopped channel takes the held value on the next cycle.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset both outputs are high, both busy flags are low, and every register reads as zero.
- R2: The control word at 0x0 reads back each channel's 10 written bits at bit 15 × channel. Bit 28 + channel reads that channel's busy flag. All other bits read 0.
- R3: A timing word holds the duty count in bits 15:0 and the period field P in bits 31:16. A period lasts P+1 counter steps. With divider code 15 the counter steps every clock. The output is active for the first D steps of each period, starting from the cycle after the edge that enables the channel.
- R4: Control bit 5 of a channel group selects the active level. A value of 1 makes the output high during the duty part of the period. A value of 0 makes it low during the duty part and high otherwise.
- R5: A duty of 0 keeps a running output at the inactive level for the whole period. A duty greater than P keeps it at the active level for the whole period.
- R6: Divider codes 0–4 step the counter once every 120, 180, 240, 360 and 480 clocks. Codes 8–12 step it once every 12000, 24000, 36000, 48000 and 72000 clocks.
- R7: Divider codes 5, 6, 7, 13 and 14 never step the counter, so a running output holds its level.
- R8: A channel runs only while both its enable bit (bit 4) and its gate bit (bit 6) are 1. A stopped channel drives its inactive level, and its divider and period counters return to zero. A restarted channel therefore begins a fresh period.
- R9: A timing write to a channel whose busy flag is high is ignored, and the word read back is unchanged.
- R10: A timing write to a running channel raises busy on its write edge. The old period and duty finish the current period. The new values apply from the next period, and busy falls at that boundary.
- R11: A timing write to a stopped channel is transferred on the following edge, so busy is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW (4) | Byte address; word 0 = control, word c+1 = timing of channel c |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 2*CW (32) | Write data |
| reg_rdata | output | 2*CW (32) | Read data for reg_addr, combinational |
| pwm_out | output | NCH (2) | PWM outputs, one per channel |
| busy | output | NCH (2) | Timing transfer pending, one per channel |

## Verification
A control write takes effect on its write edge. From the first sample after that edge, the outputs show the new level, and the period counter of a newly started channel begins at step 0. A timing write raises busy on its own edge. Busy falls one edge later for a stopped channel, or on the edge that ends the running period. The new duty shows from the sample after that edge. The scoreboard queues one expected output and busy value per clock, starting with the sample 5 ns after the write edge. A divider of 12000 clocks or more is checked by counting the samples before the output's first fall.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  // divider counter width, wide enough for the largest ratio
  localparam int PSW       = 17;
  localparam int GRPW      = 10;  // bits per channel group in the control word
  localparam int STRIDE    = 15;  // bit distance between channel groups
  localparam int BUSY_BASE = 28;  // first busy flag position in the control word

  // field positions inside a channel group
  localparam int F_EN   = 4;
  localparam int F_LVL  = 5;
  localparam int F_GATE = 6;

  // clocks per counter step; 0 marks an unused code
  function automatic logic [PSW-1:0] div_of(input logic [3:0] code);
    case (code)
      4'd0:    div_of = PSW'(120);
      4'd1:    div_of = PSW'(180);
      4'd2:    div_of = PSW'(240);
      4'd3:    div_of = PSW'(360);
      4'd4:    div_of = PSW'(480);
      4'd8:    div_of = PSW'(12000);
      4'd9:    div_of = PSW'(24000);
      4'd10:   div_of = PSW'(36000);
      4'd11:   div_of = PSW'(48000);
      4'd12:   div_of = PSW'(72000);
      4'd15:   div_of = PSW'(1);
      default: div_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm2_presc.sv
module pwm2_presc
  import pwm2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);
  logic [PSW-1:0] div;
  logic [PSW-1:0] pcnt;
  logic           live;
  logic           wrap;

  assign div  = div_of(code);
  assign live = run && (div != '0);
  // >= keeps a shrinking ratio from running the count through its full range
  assign wrap = (pcnt >= div - 1'b1);
  assign tick = live && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)              pcnt <= '0;
    else if (!live || wrap)  pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          lvl,
  input  logic [3:0]    code,
  input  logic          wr,
  input  logic [2*CW-1:0] wdata,
  output logic          out,
  output logic          busy,
  output logic [2*CW-1:0] word
);
  logic          tick;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hold_prd, hold_dty;
  logic [CW-1:0] cur_prd, cur_dty;
  logic          pend;
  logic          last_step;

  pwm2_presc u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (code),
    .tick (tick)
  );

  assign last_step = tick && (cnt == cur_prd);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (last_step)  cnt <= '0;
    else if (tick)       cnt <= cnt + 1'b1;
  end

  // holding register and transfer into the running pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_prd <= '0;
      hold_dty <= '0;
      cur_prd  <= '0;
      cur_dty  <= '0;
      pend     <= 1'b0;
    end else if (wr && !pend) begin
      hold_prd <= wdata[2*CW-1:CW];
      hold_dty <= wdata[CW-1:0];
      pend     <= 1'b1;
    end else if (pend && (!run || last_step)) begin
      cur_prd <= hold_prd;
      cur_dty <= hold_dty;
      pend    <= 1'b0;
    end
  end

  assign out  = (run && (cnt < cur_dty)) ? lvl : ~lvl;
  assign busy = pend;
  assign word = {hold_prd, hold_dty};
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH = 2,   // the control word layout holds two groups
  parameter int AW  = 4,
  parameter int CW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [2*CW-1:0] reg_wdata,
  output logic [2*CW-1:0] reg_rdata,
  output logic [NCH-1:0]  pwm_out,
  output logic [NCH-1:0]  busy
);
  localparam int DW  = 2 * CW;
  localparam int WIW = AW - 2;

  logic [NCH-1:0][GRPW-1:0] ctrl_q;
  logic [NCH-1:0][DW-1:0]   word;
  logic [NCH-1:0]           busy_w;
  logic [NCH-1:0]           wr_ch;
  logic [WIW-1:0]           widx;
  logic                     aligned;
  logic                     wr_ctrl;

  assign widx    = reg_addr[AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign wr_ctrl = reg_wr && aligned && (widx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      for (int c = 0; c < NCH; c++)
        ctrl_q[c] <= reg_wdata[STRIDE*c +: GRPW];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_ch[c] = reg_wr && aligned && (widx == WIW'(c + 1));

    pwm2_chan #(.CW(CW)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl_q[c][F_EN] && ctrl_q[c][F_GATE]),
      .lvl  (ctrl_q[c][F_LVL]),
      .code (ctrl_q[c][3:0]),
      .wr   (wr_ch[c]),
      .wdata(reg_wdata),
      .out  (pwm_out[c]),
      .busy (busy_w[c]),
      .word (word[c])
    );
  end

  assign busy = busy_w;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (widx == '0) begin
        for (int c = 0; c < NCH; c++) begin
          reg_rdata[STRIDE*c +: GRPW] = ctrl_q[c];
          reg_rdata[BUSY_BASE + c]    = busy_w[c];
        end
      end else begin
        for (int c = 0; c < NCH; c++)
          if (widx == WIW'(c + 1)) reg_rdata = word[c];
      end
    end
  end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk
  import pwm2_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [AW-1:0]            reg_addr,
  input logic                     reg_wr,
  input logic [NCH-1:0]           pwm_out,
  input logic [NCH-1:0]           busy,
  input logic [NCH-1:0][GRPW-1:0] ctrl_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic run;
    logic unused_code;
    assign run = ctrl_q[c][F_EN] && ctrl_q[c][F_GATE];
    assign unused_code = (div_of(ctrl_q[c][3:0]) == '0);

    // R8
    stop_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> pwm_out[c] == ~ctrl_q[c][F_LVL]);

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[c]) |-> $past(reg_wr && reg_addr == AW'(4 * (c + 1))));

    // R11
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] && !run |=> !busy[c]);

    // R7
    frozen_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && unused_code && $stable(ctrl_q[c]) |-> $stable(pwm_out[c]));
  end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_addr(reg_addr),
  .reg_wr  (reg_wr),
  .pwm_out (pwm_out),
  .busy    (busy),
  .ctrl_q  (ctrl_q)
);

// File: tb/pwm2_ctrl_tb_top.sv
module pwm2_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam int CW  = 16;
  localparam int DW  = 2 * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] busy;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int    ch;
    bit    val;
    bit    chk_b;
    bit    bval;
    string tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;  // 50 MHz

  pwm2_ctrl #(.NCH(NCH), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per clock, sampled 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(pwm_out[it.ch] == it.val, {it.tag, " output"}, pwm_out[it.ch], it.val);
      if (it.chk_b) check(busy[it.ch] == it.bval, {it.tag, " busy"}, busy[it.ch], it.bval);
    end
  end

  task automatic push_wave(input int ch, input int p, input int d, input bit lvl,
                           input int div, input int n, input bit chk_b, input bit bval,
                           input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      int k;
      k = (i / div) % (p + 1);
      it.ch = ch; it.val = (k < d) ? lvl : ~lvl;
      it.chk_b = chk_b; it.bval = bval; it.tag = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic push_const(input int ch, input bit v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.ch = ch; it.val = v; it.chk_b = 1'b0; it.bval = 1'b0; it.tag = tag;
      sbq.push_back(it);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  // counts samples with channel 1 high after an enable write
  task automatic measure_high(input logic [DW-1:0] ctl, input int exp, input string tag);
    int n;
    wr(0, ctl);
    @(posedge clk); #5;
    reg_wr = 1'b0;
    n = 0;
    while (pwm_out[1] && n < 100000) begin
      n++;
      @(posedge clk); #5;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    check(pwm_out == 2'b11, "R1 outputs", pwm_out, 2'b11);
    check(busy == 2'b00, "R1 busy", busy, 0);
    rd_chk(0, 0, "R1 control");
    rd_chk(4, 0, "R1 timing 0");
    rd_chk(8, 0, "R1 timing 1");

    // R2 control readback at the 15-bit stride
    wr(0, 32'h2AA | (32'h155 << 15));
    cyc();
    rd_chk(0, 32'h2AA | (32'h155 << 15), "R2 control readback");
    wr(0, 0);
    cyc();

    // R11 stopped channel: busy high for one cycle, shown at bit 28
    wr(4, (32'd4 << 16) | 32'd2);
    push_wave(0, 0, 0, 1'b0, 1, 1, 1'b1, 1'b1, "R11");
    push_wave(0, 0, 0, 1'b0, 1, 1, 1'b1, 1'b0, "R11");
    rd_chk(0, 32'h1000_0000, "R2 busy bit");
    cyc();
    rd_chk(4, (32'd4 << 16) | 32'd2, "R11 word stored");

    // R3 bypass divider, active high, P=4 D=2
    wr(0, 32'h7F);
    push_wave(0, 4, 2, 1'b1, 1, 15, 1'b1, 1'b0, "R3");
    repeat (14) cyc();

    // R10 deferred load on the period boundary
    wr(4, (32'd2 << 16) | 32'd1);
    push_wave(0, 4, 2, 1'b1, 1, 5, 1'b1, 1'b1, "R10 old period");
    push_wave(0, 2, 1, 1'b1, 1, 9, 1'b1, 1'b0, "R10 new period");
    // R9 write while busy is refused
    wr(4, (32'd7 << 16) | 32'd7);
    repeat (14) cyc();
    rd_chk(4, (32'd2 << 16) | 32'd1, "R9 refused write");

    // R8 gate cleared forces inactive level, restart begins a fresh period
    wr(0, 32'h3F);
    push_const(0, 1'b0, 4, "R8 stopped");
    repeat (4) cyc();
    wr(0, 32'h7F);
    push_wave(0, 2, 1, 1'b1, 1, 6, 1'b0, 1'b0, "R8 restart");
    repeat (6) cyc();

    // R5 duty zero and duty above the period field
    wr(0, 32'h3F); cyc();
    wr(4, (32'd3 << 16)); cyc(); cyc();
    wr(0, 32'h7F);
    push_const(0, 1'b0, 10, "R5 duty zero");
    repeat (10) cyc();
    wr(0, 32'h3F); cyc();
    wr(4, (32'd3 << 16) | 32'd9); cyc(); cyc();
    wr(0, 32'h7F);
    push_const(0, 1'b1, 10, "R5 full duty");
    repeat (10) cyc();

    // R4 active-low polarity
    wr(0, 32'h3F); cyc();
    wr(4, (32'd4 << 16) | 32'd2); cyc(); cyc();
    wr(0, 32'h5F);
    push_wave(0, 4, 2, 1'b0, 1, 15, 1'b0, 1'b0, "R4");
    repeat (15) cyc();
    wr(0, 0); cyc(); cyc();

    // R6 divider table on channel 1, P=1 D=1
    wr(8, (32'd1 << 16) | 32'd1); cyc(); cyc();
    wr(0, 32'h70 << 15);
    push_wave(1, 1, 1, 1'b1, 120, 480, 1'b0, 1'b0, "R6 code 0");
    repeat (480) cyc();
    wr(0, 0); cyc();
    wr(0, 32'h73 << 15);
    push_wave(1, 1, 1, 1'b1, 360, 1440, 1'b0, 1'b0, "R6 code 3");
    repeat (1440) cyc();
    wr(0, 0); cyc();
    measure_high(32'h78 << 15, 12000, "R6 code 8");
    wr(0, 0); cyc();
    measure_high(32'h7C << 15, 72000, "R6 code 12");
    wr(0, 0); cyc();

    // R7 unused codes freeze the counter
    wr(0, 32'h75 << 15);
    push_const(1, 1'b1, 40, "R7 code 5");
    repeat (40) cyc();
    wr(0, 0); cyc();
    wr(0, 32'h7E << 15);
    push_const(1, 1'b1, 40, "R7 code 14");
    repeat (40) cyc();
    wr(0, 0);
    repeat (3) cyc();
    finish_run();
  end
endmodule